// File: doc/BRIEF.md
# Extended Hamming Single-Correct Double-Detect Codec

This block holds a combinational encoder and a combinational decoder for an extended Hamming code. The encoder takes `INFO_W` information bits and builds a code word. Check bits sit at the power-of-two positions of the word, and an overall parity bit is added to make the code double-detecting. The number of check bits is derived from `INFO_W`: it is the smallest `k` for which `2^k >= INFO_W + k + 1`. The default build carries 4 information bits in an 8-bit word.

The decoder takes a received word and recomputes every parity group. The groups form a syndrome that, read as an integer, is the 1-origin position of a single failing bit. From the syndrome and the overall parity the decoder classifies the word as clean, corrected or uncorrectable. It flips the indicated bit only when correction is safe. It also reports the syndrome so that the surrounding logic can log where errors fall.

A build parameter selects how the overall parity bit is formed. It can be taken over the whole Hamming portion, or over only the even positions, with the odd half supplied by the lowest check bit. Both variants produce the same code word. They differ only in the parity tree they build.

Top module: `hamSecdedCodec`

## Requirements
- R1: Code word bit 0 is the overall parity bit, and bit `p` (1 ≤ p ≤ n) is Hamming position `p`. Information bit `j` sits at the `j`-th non-power-of-two position in ascending order. For the default build, info bits 0..3 sit at positions 3, 5, 6 and 7.
- R2: The check bit at position `2^i` gives even parity over every position `p` in 1..n whose index has bit `i` set.
- R3: The overall parity bit makes the XOR of all `n+1` code word bits equal to 0.
- R4: A received word with no flipped bit yields status `00`, syndrome 0, and the original information bits.
- R5: A single flip at any position `p` in 1..n yields status `01` and syndrome `p`. The information output equals the originally encoded bits.
- R6: A single flip of bit 0 (the overall parity bit) yields status `01` and syndrome 0, with the information output unchanged. A single flip of a check bit also leaves the information output equal to the received information bits.
- R7: Any two flips yield status `10`. The syndrome equals the XOR of the two flipped indices, and the information output equals the received information bits with no correction applied.
- R8: Status `11` is never produced.
- R9: The even-positions parity variant produces the same code word and the same decoder outputs as the full-word variant for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| infoIn | input | INFO_W | Information bits to encode |
| codeOut | output | n+1 | Encoded word; bit 0 is the overall parity bit |
| codeIn | input | n+1 | Received word to decode |
| infoOut | output | INFO_W | Information bits after any correction |
| status | output | 2 | 00 clean, 01 single error handled, 10 double error |
| syndrome | output | k | Recomputed parity groups; the failing position when one error occurred |

## Verification
The immediate assertions run on every evaluation. They check that status `11` never appears and that a correction is never applied while a double error is flagged. They also check that the decoder changes at most one bit of the received word, that a correction only happens with odd overall parity, and that every encoded word has even overall parity. Only the bench scenarios can show that the flipped bit is the right one and that the syndrome equals the failing position. The bench does this by sweeping every information value with no flip, with each single flip and with each pair of flips, and by adding random draws. Only the bench can also show that the two parity variants agree word for word.

// File: rtl/hamPkg.sv
package hamPkg;

  // Smallest check-bit count covering m information bits plus itself and the no-error case
  function automatic int checkBits(input int m);
    int k;
    k = 0;
    while ((1 << k) < (m + k + 1)) k++;
    return k;
  endfunction

  function automatic bit isPow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // Strobes from the decode control to the decode datapath
  typedef struct packed {
    logic flipEn;    // flip the position named by the syndrome
    logic markCorr;  // single error handled
    logic markDbl;   // uncorrectable
  } fixStrobe_t;

endpackage

// File: rtl/hamEncoder.sv
module hamEncoder #(
  parameter int INFO_W = 4,
  parameter bit EVEN_PARITY_SRC = 1'b0,
  localparam int K = hamPkg::checkBits(INFO_W),
  localparam int N = INFO_W + K
) (
  input  logic [INFO_W-1:0] infoIn,
  output logic [N:0]        codeOut
);

  logic [N:0] secWord;

  always_comb begin
    int j;
    secWord = '0;
    j = 0;
    for (int p = 1; p <= N; p++) begin
      if (!hamPkg::isPow2(p)) begin
        secWord[p] = infoIn[j];
        j++;
      end
    end
    for (int i = 0; i < K; i++) begin
      logic par;
      par = 1'b0;
      for (int p = 1; p <= N; p++) begin
        if (((p >> i) & 1) == 1) par ^= secWord[p];
      end
      secWord[1 << i] = par;
    end
  end

  logic overallBit;

  generate
    if (EVEN_PARITY_SRC) begin : gEvenSrc
      // Odd positions already XOR to zero through the lowest check bit
      always_comb begin
        overallBit = 1'b0;
        for (int p = 2; p <= N; p += 2) overallBit ^= secWord[p];
      end
    end else begin : gFullSrc
      always_comb overallBit = ^secWord[N:1];
    end
  endgenerate

  always_comb begin
    codeOut    = secWord;
    codeOut[0] = overallBit;
  end

  // R3
  always_comb begin
    enc_parity_chk: assert ((^codeOut) == 1'b0)
      else $error("encoded word has odd overall parity");
  end

endmodule

// File: rtl/hamDecodePath.sv
module hamDecodePath #(
  parameter int INFO_W = 4,
  parameter bit EVEN_PARITY_SRC = 1'b0,
  localparam int K = hamPkg::checkBits(INFO_W),
  localparam int N = INFO_W + K
) (
  input  logic [N:0]          codeIn,
  input  hamPkg::fixStrobe_t  strobe,
  output logic [K-1:0]        syn,
  output logic                ovOdd,
  output logic [INFO_W-1:0]   infoOut
);

  always_comb begin
    syn = '0;
    for (int i = 0; i < K; i++) begin
      for (int p = 1; p <= N; p++) begin
        if (((p >> i) & 1) == 1) syn[i] ^= codeIn[p];
      end
    end
  end

  generate
    if (EVEN_PARITY_SRC) begin : gEvenChk
      always_comb begin
        ovOdd = codeIn[0] ^ syn[0];
        for (int p = 2; p <= N; p += 2) ovOdd ^= codeIn[p];
      end
    end else begin : gFullChk
      always_comb ovOdd = ^codeIn;
    end
  endgenerate

  logic [N:0] fixedWord;

  always_comb begin
    fixedWord = codeIn;
    for (int p = 1; p <= N; p++) begin
      if (strobe.flipEn && (int'(syn) == p)) fixedWord[p] = ~codeIn[p];
    end
  end

  always_comb begin
    int j;
    infoOut = '0;
    j = 0;
    for (int p = 1; p <= N; p++) begin
      if (!hamPkg::isPow2(p)) begin
        infoOut[j] = fixedWord[p];
        j++;
      end
    end
  end

  // R5
  always_comb begin
    single_flip_chk: assert ($countones(fixedWord ^ codeIn) <= 1)
      else $error("decoder altered more than one bit");
  end

endmodule

// File: rtl/hamDecodeCtrl.sv
module hamDecodeCtrl #(
  parameter int INFO_W = 4,
  localparam int K = hamPkg::checkBits(INFO_W),
  localparam int N = INFO_W + K
) (
  input  logic [K-1:0]        syn,
  input  logic                ovOdd,
  output hamPkg::fixStrobe_t  strobe
);

  logic inRange;

  always_comb begin
    inRange         = int'(syn) <= N;
    strobe.markCorr = ovOdd && inRange;
    strobe.flipEn   = ovOdd && inRange && (syn != '0);
    strobe.markDbl  = !(ovOdd && inRange) && (ovOdd || (syn != '0));
  end

  // R7
  always_comb begin
    dbl_no_flip_chk: assert (!(strobe.markDbl && strobe.flipEn))
      else $error("correction attempted on double error");
  end

  // R5
  always_comb begin
    corr_needs_odd_chk: assert (!strobe.flipEn || ovOdd)
      else $error("correction with even overall parity");
  end

endmodule

// File: rtl/hamSecdedCodec.sv
module hamSecdedCodec #(
  parameter int INFO_W = 4,
  parameter bit EVEN_PARITY_SRC = 1'b0,
  localparam int K = hamPkg::checkBits(INFO_W),
  localparam int N = INFO_W + K
) (
  input  logic [INFO_W-1:0] infoIn,
  output logic [N:0]        codeOut,
  input  logic [N:0]        codeIn,
  output logic [INFO_W-1:0] infoOut,
  output logic [1:0]        status,
  output logic [K-1:0]      syndrome
);

  hamPkg::fixStrobe_t fixStrobe;
  logic               ovOdd;

  hamEncoder #(.INFO_W(INFO_W), .EVEN_PARITY_SRC(EVEN_PARITY_SRC)) encU (
    .infoIn (infoIn),
    .codeOut(codeOut)
  );

  hamDecodePath #(.INFO_W(INFO_W), .EVEN_PARITY_SRC(EVEN_PARITY_SRC)) pathU (
    .codeIn (codeIn),
    .strobe (fixStrobe),
    .syn    (syndrome),
    .ovOdd  (ovOdd),
    .infoOut(infoOut)
  );

  hamDecodeCtrl #(.INFO_W(INFO_W)) ctrlU (
    .syn   (syndrome),
    .ovOdd (ovOdd),
    .strobe(fixStrobe)
  );

  assign status = {fixStrobe.markDbl, fixStrobe.markCorr};

  // R8
  always_comb begin
    status_legal_chk: assert (status != 2'b11)
      else $error("illegal status code");
  end

endmodule

// File: tb/hamSecdedCodec_test.sv
module hamSecdedCodec_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [3:0] infoIn;
  logic [7:0] codeIn;
  logic [7:0] codeOut, codeOutE;
  logic [3:0] infoOut, infoOutE;
  logic [1:0] status, statusE;
  logic [2:0] syndrome, syndromeE;

  int vecCnt = 0;
  int failCnt = 0;

  hamSecdedCodec #(.INFO_W(4), .EVEN_PARITY_SRC(1'b0)) uut (
    .infoIn(infoIn), .codeOut(codeOut), .codeIn(codeIn),
    .infoOut(infoOut), .status(status), .syndrome(syndrome)
  );

  hamSecdedCodec #(.INFO_W(4), .EVEN_PARITY_SRC(1'b1)) uutEven (
    .infoIn(infoIn), .codeOut(codeOutE), .codeIn(codeIn),
    .infoOut(infoOutE), .status(statusE), .syndrome(syndromeE)
  );

  // Reference encoder: info bits at positions 3,5,6,7; checks at 1,2,4; overall at bit 0
  function automatic logic [7:0] refEncode(input logic [3:0] d);
    logic [7:0] w;
    w = '0;
    w[3] = d[0]; w[5] = d[1]; w[6] = d[2]; w[7] = d[3];
    w[1] = w[3] ^ w[5] ^ w[7];
    w[2] = w[3] ^ w[6] ^ w[7];
    w[4] = w[5] ^ w[6] ^ w[7];
    w[0] = ^w[7:1];
    return w;
  endfunction

  function automatic logic [3:0] refInfo(input logic [7:0] w);
    return {w[7], w[6], w[5], w[3]};
  endfunction

  function automatic logic [2:0] refSyn(input logic [7:0] mask);
    logic [2:0] s;
    s = '0;
    for (int b = 1; b < 8; b++) if (mask[b]) s ^= 3'(b);
    return s;
  endfunction

  task automatic applyVec(input logic [3:0] d, input logic [7:0] mask);
    logic [7:0] rx;
    logic [1:0] expStat;
    logic [3:0] expInfo;
    logic [2:0] expSyn;
    int flips;
    string tag;
    @(negedge clk);
    rx = refEncode(d) ^ mask;
    infoIn = d;
    codeIn = rx;
    flips = $countones(mask);
    expSyn = refSyn(mask);
    if (flips == 0) begin
      expStat = 2'b00; expInfo = d; tag = "R4";
    end else if (flips == 1) begin
      expStat = 2'b01; expInfo = d;
      tag = (mask[0] || mask[1] || mask[2] || mask[4]) ? "R6" : "R5";
    end else begin
      expStat = 2'b10; expInfo = refInfo(rx); tag = "R7";
    end
    #2;
    vecCnt++;
    // R1 R2 R3: encoder word against reference
    if (codeOut !== refEncode(d)) begin
      failCnt++;
      $display("FAIL R1/R2/R3 codeOut d=%h got %b exp %b", d, codeOut, refEncode(d));
    end
    if (status !== expStat || syndrome !== expSyn || infoOut !== expInfo) begin
      failCnt++;
      $display("FAIL %s d=%h mask=%b got st=%b syn=%0d info=%h exp st=%b syn=%0d info=%h",
               tag, d, mask, status, syndrome, infoOut, expStat, expSyn, expInfo);
    end
    // R8
    if (status === 2'b11) begin
      failCnt++;
      $display("FAIL R8 status got 11 exp not 11");
    end
    // R9
    if (codeOutE !== codeOut || statusE !== status || syndromeE !== syndrome || infoOutE !== infoOut) begin
      failCnt++;
      $display("FAIL R9 even variant got %b/%b/%0d/%h exp %b/%b/%0d/%h",
               codeOutE, statusE, syndromeE, infoOutE, codeOut, status, syndrome, infoOut);
    end
  endtask

  initial begin
    #(8 * 200000);
    failCnt++;
    $display("FAIL watchdog got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    infoIn = '0;
    codeIn = '0;
    repeat (2) @(negedge clk);
    // R4: quiescent all-zero word
    applyVec(4'h0, 8'h00);
    // Directed corners: R6 parity-bit flip, R5 top position, R7 pair incl. parity bit
    applyVec(4'hF, 8'b0000_0001);
    applyVec(4'hA, 8'b1000_0000);
    applyVec(4'h5, 8'b0000_1001);
    // Exhaustive sweep: no flip, every single flip, every pair
    for (int d = 0; d < 16; d++) begin
      applyVec(4'(d), 8'h00);
      for (int a = 0; a < 8; a++) begin
        applyVec(4'(d), 8'(1 << a));
        for (int b = a + 1; b < 8; b++) applyVec(4'(d), 8'((1 << a) | (1 << b)));
      end
    end
    // Random draws of 0, 1 or 2 distinct flips
    for (int r = 0; r < 300; r++) begin
      logic [7:0] m;
      int nf;
      int a;
      int b;
      nf = $urandom % 3;
      a = $urandom % 8;
      b = (a + 1 + ($urandom % 7)) % 8;
      m = '0;
      if (nf >= 1) m[a] = 1'b1;
      if (nf == 2) m[b] = 1'b1;
      applyVec(4'($urandom % 16), m);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

endmodule